// File: doc/BRIEF.md
# Aliased Banked CPU Register File

This block holds the programmer-visible register state of a small CPU core. It has four 16-bit data registers, six 24-bit address-class registers, two 24-bit stack pointers and a 16-bit flag word. Two of the address-class registers are the static base and the frame base. The other four are two address registers, the program counter and the interrupt vector table base. Two combinational read ports and one write port select a register with a 4-bit code and a 2-bit access size. The same storage can be reached in more than one way. The low two data registers also split into byte halves. Data registers are joined in pairs to give 32-bit values. A code for the active stack pointer reaches either the user copy or the interrupt copy, depending on a flag bit.

A separate flag-update input sets the carry, zero and sign flags from an operation result. The zero and sign flags are judged at the size of that result. Instruction decode, the ALU and memory access sit outside this block and drive these ports.

Size codes are 0 = byte, 1 = word and 2 = long; code 3 is never legal. The legal register codes for each size are:

| Size | Legal codes |
|------|-------------|
| byte | 0 = low half of D0, 1 = high half of D0, 2 = low half of D1, 3 = high half of D1 |
| word | 0..3 = D0..D3, 4 = A0, 5 = A1, 6 = static base, 7 = frame base, 8 = program counter, 9 = vector table base, 10 = active stack pointer, 11 = user stack pointer, 12 = interrupt stack pointer, 13 = flag word |
| long | 0 = D2:D0, 1 = D3:D1 |

Flag bits are carry = bit 0, debug = bit 1, zero = bit 2, sign = bit 3 and stack select = bit 7.

Top module: `cpu_regfile`

## Requirements
- R1: After reset, every legal read on either port returns 0. The active stack pointer code therefore shows the interrupt stack pointer.
- R2: A byte write changes only the addressed 8 bits of D0 or D1. A byte read returns that half, zero-extended to 32 bits.
- R3: A long access to code 0 joins D2 (bits 31:16) with D0 (bits 15:0). A long access to code 1 joins D3 with D1 in the same way. A long write updates both registers.
- R4: A word write to a 24-bit register (codes 4..9, 11, 12) stores data bits 23:0. A word read returns the register zero-extended to 32 bits. A word read of a data register returns it zero-extended.
- R5: Code 10 reads and writes the user stack pointer when flag bit 7 is 1, and the interrupt stack pointer when it is 0.
- R6: Flag bit 1 always reads 0. A write that sets it leaves it 0, and the other 15 bits are written as given.
- R7: When fu_en is high, the next flag state has carry = fu_carry. Zero is 1 exactly when the result is zero at the size given by fu_size, and sign equals the result's top bit at that size: bit 7 for byte, bit 15 for word, bit 31 for long or size 3.
- R8: A size and code pair outside the table above sets the matching illegal output. A read of such a pair returns 0, and a write of it changes no register.
- R9: When a flag-word write and a flag update happen in the same cycle, bits 0, 2 and 3 take the update's values. All other bits take the written value, with bit 1 held at 0.
- R10: Both read ports are combinational and independent of each other. A write becomes visible on the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_size | input | 2 | Read port A access size |
| ra_sel | input | 4 | Read port A register code |
| ra_data | output | 32 | Read port A data |
| ra_illegal | output | 1 | Read port A selection is not legal |
| rb_size | input | 2 | Read port B access size |
| rb_sel | input | 4 | Read port B register code |
| rb_data | output | 32 | Read port B data |
| rb_illegal | output | 1 | Read port B selection is not legal |
| we | input | 1 | Write enable |
| w_size | input | 2 | Write access size |
| w_sel | input | 4 | Write register code |
| w_data | input | 32 | Write data |
| w_illegal | output | 1 | Write selection is not legal |
| fu_en | input | 1 | Flag update enable |
| fu_size | input | 2 | Size at which the result is judged |
| fu_result | input | 32 | Operation result |
| fu_carry | input | 1 | Carry or borrow from the operation |

## Verification
The assertions check the following on every cycle:
- the debug flag stays clear;
- an illegal write leaves all stored state unchanged;
- an illegal read returns zero;
- the carry flag and the long-size zero flag follow a flag update;
- the active stack pointer code returns the interrupt copy whenever the stack select bit is low.

Other behaviours can only be shown by the bench's scenarios, because they depend on a sequence of writes and reads:
- a byte write leaves the other half of the register unchanged;
- the long pairs split across two word registers;
- a write to the active stack pointer goes to the copy that bit 7 selects;
- an update beats a simultaneous flag-word write on bits 0, 2 and 3.

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DW = 16,
  parameter int AW = 24,
  parameter int FW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ra_size,
  input  logic [3:0]      ra_sel,
  output logic [2*DW-1:0] ra_data,
  output logic            ra_illegal,
  input  logic [1:0]      rb_size,
  input  logic [3:0]      rb_sel,
  output logic [2*DW-1:0] rb_data,
  output logic            rb_illegal,
  input  logic            we,
  input  logic [1:0]      w_size,
  input  logic [3:0]      w_sel,
  input  logic [2*DW-1:0] w_data,
  output logic            w_illegal,
  input  logic            fu_en,
  input  logic [1:0]      fu_size,
  input  logic [2*DW-1:0] fu_result,
  input  logic            fu_carry
);
  localparam int LW = 2 * DW;
  localparam int BW = DW / 2;
  localparam int NA = 8;
  localparam int USP = 6;
  localparam int ISP = 7;
  localparam logic [FW-1:0] DMASK = FW'(2);

  logic [DW-1:0] dreg [4];
  logic [AW-1:0] areg [NA];
  logic [FW-1:0] flg;

  wire       u_bit = flg[7];
  wire [2:0] sp_ix = u_bit ? 3'(USP) : 3'(ISP);

  function automatic logic legal(input logic [1:0] sz, input logic [3:0] sl);
    case (sz)
      2'd0:    return sl < 4'd4;
      2'd1:    return sl < 4'd14;
      2'd2:    return sl < 4'd2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LW-1:0] zx_a(input logic [AW-1:0] v);
    return {{(LW-AW){1'b0}}, v};
  endfunction

  function automatic logic [LW-1:0] rd(input logic [1:0] sz, input logic [3:0] sl);
    logic [LW-1:0] v;
    v = '0;
    if (legal(sz, sl)) begin
      case (sz)
        2'd0: v = {{(LW-BW){1'b0}}, sl[0] ? dreg[{1'b0, sl[1]}][DW-1:BW]
                                            : dreg[{1'b0, sl[1]}][BW-1:0]};
        2'd2: v = {dreg[{1'b1, sl[0]}], dreg[{1'b0, sl[0]}]};
        default: begin
          if (sl < 4'd4)       v = {{(LW-DW){1'b0}}, dreg[sl[1:0]]};
          else if (sl < 4'd10) v = zx_a(areg[3'(sl - 4'd4)]);
          else if (sl == 4'd10) v = zx_a(areg[sp_ix]);
          else if (sl == 4'd11) v = zx_a(areg[USP]);
          else if (sl == 4'd12) v = zx_a(areg[ISP]);
          else                  v = {{(LW-FW){1'b0}}, flg};
        end
      endcase
    end
    return v;
  endfunction

  assign ra_illegal = !legal(ra_size, ra_sel);
  assign rb_illegal = !legal(rb_size, rb_sel);
  assign w_illegal  = !legal(w_size, w_sel);
  assign ra_data    = rd(ra_size, ra_sel);
  assign rb_data    = rd(rb_size, rb_sel);

  logic fz, fs;
  always_comb begin
    case (fu_size)
      2'd0: begin fz = ~|fu_result[BW-1:0]; fs = fu_result[BW-1]; end
      2'd1: begin fz = ~|fu_result[DW-1:0]; fs = fu_result[DW-1]; end
      default: begin fz = ~|fu_result; fs = fu_result[LW-1]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) dreg[i] <= '0;
      for (int i = 0; i < NA; i++) areg[i] <= '0;
      flg <= '0;
    end else begin
      if (we && !w_illegal) begin
        case (w_size)
          2'd0: begin
            if (w_sel[0]) dreg[{1'b0, w_sel[1]}][DW-1:BW] <= w_data[BW-1:0];
            else          dreg[{1'b0, w_sel[1]}][BW-1:0]  <= w_data[BW-1:0];
          end
          2'd2: begin
            dreg[{1'b1, w_sel[0]}] <= w_data[LW-1:DW];
            dreg[{1'b0, w_sel[0]}] <= w_data[DW-1:0];
          end
          default: begin
            if (w_sel < 4'd4)        dreg[w_sel[1:0]] <= w_data[DW-1:0];
            else if (w_sel < 4'd10)  areg[3'(w_sel - 4'd4)] <= w_data[AW-1:0];
            else if (w_sel == 4'd10) areg[sp_ix] <= w_data[AW-1:0];
            else if (w_sel == 4'd11) areg[USP] <= w_data[AW-1:0];
            else if (w_sel == 4'd12) areg[ISP] <= w_data[AW-1:0];
            else                     flg <= w_data[FW-1:0] & ~DMASK;
          end
        endcase
      end
      if (fu_en) begin
        flg[0] <= fu_carry;
        flg[2] <= fz;
        flg[3] <= fs;
      end
    end
  end
endmodule

module cpu_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic        w_illegal,
  input logic        fu_en,
  input logic [1:0]  fu_size,
  input logic [31:0] fu_result,
  input logic        fu_carry,
  input logic [1:0]  ra_size,
  input logic [3:0]  ra_sel,
  input logic [31:0] ra_data,
  input logic        ra_illegal,
  input logic [15:0] flg,
  input logic [23:0] isp,
  input logic [255:0] state
);
  // R6
  dbit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) flg[1] == 1'b0);
  // R8
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && w_illegal && !fu_en) |=> ($stable(state) && $stable(flg)));
  // R8
  illegal_rdzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_illegal |-> ra_data == 32'h0);
  // R7
  carry_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fu_en |=> flg[0] == $past(fu_carry));
  // R7
  zero_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_en && fu_size == 2'd2) |=> flg[2] == ($past(fu_result) == 32'h0));
  // R5
  sp_isp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_size == 2'd1 && ra_sel == 4'd10 && !flg[7]) |-> ra_data == {8'h0, isp});
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .w_illegal(w_illegal), .fu_en(fu_en),
  .fu_size(fu_size), .fu_result(fu_result), .fu_carry(fu_carry),
  .ra_size(ra_size), .ra_sel(ra_sel), .ra_data(ra_data), .ra_illegal(ra_illegal),
  .flg(flg), .isp(areg[7]),
  .state({dreg[0], dreg[1], dreg[2], dreg[3], areg[0], areg[1], areg[2], areg[3],
          areg[4], areg[5], areg[6], areg[7]})
);

// File: tb/tb_cpu_regfile.sv
module tb_cpu_regfile;
  logic clk = 0, rst_n = 0;
  logic [1:0] ra_size = 0, rb_size = 0, w_size = 0, fu_size = 0;
  logic [3:0] ra_sel = 0, rb_sel = 0, w_sel = 0;
  logic [31:0] ra_data, rb_data, w_data = 0, fu_result = 0;
  logic ra_illegal, rb_illegal, w_illegal, we = 0, fu_en = 0, fu_carry = 0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_regfile dut (.*);

  logic [15:0] m_d [4];
  logic [23:0] m_a [8];
  logic [15:0] m_f;

  function automatic logic m_legal(input logic [1:0] sz, input logic [3:0] sl);
    if (sz == 0) return sl < 4;
    if (sz == 1) return sl < 14;
    if (sz == 2) return sl < 2;
    return 0;
  endfunction

  function automatic logic [31:0] m_rd(input logic [1:0] sz, input logic [3:0] sl);
    if (!m_legal(sz, sl)) return 0;
    if (sz == 0) return sl[0] ? {24'h0, m_d[sl[1]][15:8]} : {24'h0, m_d[sl[1]][7:0]};
    if (sz == 2) return {m_d[2 + sl[0]], m_d[sl[0]]};
    if (sl < 4) return {16'h0, m_d[sl]};
    if (sl < 10) return {8'h0, m_a[sl - 4]};
    if (sl == 10) return {8'h0, m_f[7] ? m_a[6] : m_a[7]};
    if (sl == 11) return {8'h0, m_a[6]};
    if (sl == 12) return {8'h0, m_a[7]};
    return {16'h0, m_f};
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input logic [3:0] sl);
    if (!m_legal(sz, sl)) return "R8";
    if (sz == 0) return "R2";
    if (sz == 2) return "R3";
    if (sl == 10) return "R5";
    if (sl == 13) return "R6";
    if (sl >= 4) return "R4";
    return "R10";
  endfunction

  task automatic m_apply();
    logic z, s;
    if (we && m_legal(w_size, w_sel)) begin
      if (w_size == 0) begin
        if (w_sel[0]) m_d[w_sel[1]][15:8] = w_data[7:0];
        else          m_d[w_sel[1]][7:0] = w_data[7:0];
      end else if (w_size == 2) begin
        m_d[2 + w_sel[0]] = w_data[31:16];
        m_d[w_sel[0]] = w_data[15:0];
      end else if (w_sel < 4) m_d[w_sel] = w_data[15:0];
      else if (w_sel < 10) m_a[w_sel - 4] = w_data[23:0];
      else if (w_sel == 10) begin
        if (m_f[7]) m_a[6] = w_data[23:0]; else m_a[7] = w_data[23:0];
      end
      else if (w_sel == 11) m_a[6] = w_data[23:0];
      else if (w_sel == 12) m_a[7] = w_data[23:0];
      else m_f = w_data[15:0] & 16'hFFFD;
    end
    if (fu_en) begin
      if (fu_size == 0) begin z = fu_result[7:0] == 0; s = fu_result[7]; end
      else if (fu_size == 1) begin z = fu_result[15:0] == 0; s = fu_result[15]; end
      else begin z = fu_result == 0; s = fu_result[31]; end
      m_f[0] = fu_carry; m_f[2] = z; m_f[3] = s;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic w, input logic [1:0] sz, input logic [3:0] sl,
                    input logic [31:0] d, input logic fe, input logic [1:0] fs,
                    input logic [31:0] fr, input logic fc);
    @(negedge clk);
    we = w; w_size = sz; w_sel = sl; w_data = d;
    fu_en = fe; fu_size = fs; fu_result = fr; fu_carry = fc;
    @(posedge clk);
    m_apply();
    @(negedge clk);
    we = 0; fu_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [3:0] sl);
    @(negedge clk);
    ra_size = sz; ra_sel = sl;
    #1 chk(tag, ra_data, m_rd(sz, sl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) m_d[i] = 0;
    for (int i = 0; i < 8; i++) m_a[i] = 0;
    m_f = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        ra_size = 2'(s); ra_sel = 4'(c);
        #1 chk("R1", ra_data, 32'h0);
      end

    op(1, 1, 0, 32'h1234, 0, 0, 0, 0);
    op(1, 0, 1, 32'hAB, 0, 0, 0, 0);
    rd_chk("R2", 1, 0);
    op(1, 0, 2, 32'h5A, 0, 0, 0, 0);
    rd_chk("R2", 1, 1);
    op(1, 2, 1, 32'hDEADBEEF, 0, 0, 0, 0);
    rd_chk("R3", 1, 3);
    rd_chk("R3", 1, 1);
    rd_chk("R3", 2, 0);
    op(1, 1, 8, 32'hFFABCDEF, 0, 0, 0, 0);
    rd_chk("R4", 1, 8);
    op(1, 1, 10, 32'h111111, 0, 0, 0, 0);
    rd_chk("R5", 1, 12);
    op(1, 1, 13, 32'h0082, 0, 0, 0, 0);
    rd_chk("R6", 1, 13);
    op(1, 1, 10, 32'h222222, 0, 0, 0, 0);
    rd_chk("R5", 1, 11);
    rd_chk("R5", 1, 10);
    op(1, 1, 13, 32'h0, 0, 0, 0, 0);
    rd_chk("R5", 1, 10);
    op(0, 0, 0, 0, 1, 0, 32'h100, 1);
    rd_chk("R7", 1, 13);
    op(0, 0, 0, 0, 1, 0, 32'h80, 0);
    rd_chk("R7", 1, 13);
    op(0, 0, 0, 0, 1, 1, 32'h10000, 1);
    rd_chk("R7", 1, 13);
    op(1, 1, 13, 32'hFFFF, 1, 2, 32'h1, 0);
    rd_chk("R9", 1, 13);
    chk("R9", {16'h0, m_f}, 32'hFFF0);
    @(negedge clk);
    we = 1; w_size = 0; w_sel = 5; w_data = 32'hFF;
    #1 chk("R8", {31'h0, w_illegal}, 32'h1);
    @(posedge clk);
    @(negedge clk) we = 0;
    for (int c = 0; c < 4; c++) rd_chk("R8", 1, 4'(c));

    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      we = $urandom; w_size = 2'($urandom); w_sel = 4'($urandom % 15);
      w_data = $urandom;
      fu_en = ($urandom % 4) == 0; fu_size = 2'($urandom);
      fu_result = ($urandom % 5 == 0) ? 32'h0 : $urandom; fu_carry = $urandom;
      ra_size = 2'($urandom); ra_sel = 4'($urandom % 15);
      rb_size = 2'($urandom); rb_sel = 4'($urandom % 15);
      #1;
      chk(tag_of(ra_size, ra_sel), ra_data, m_rd(ra_size, ra_sel));
      chk("R10", rb_data, m_rd(rb_size, rb_sel));
      chk("R8", {31'h0, w_illegal}, {31'h0, !m_legal(w_size, w_sel)});
      @(posedge clk);
      m_apply();
    end
    @(negedge clk);
    we = 0; fu_en = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule